// File: doc/BRIEF.md
# Absence Schedule Start-Time Aligner

This block loads up to two absence descriptors into the register file of a wireless power-save scheduler. A descriptor has a duration, a repeat interval, a requested start time and a count/type byte. The timer input is captured once when each descriptor begins. The start time is then moved forward in whole intervals until it lies beyond that captured value plus a fixed guard of 51200 ticks. Each step uses up one unit of the count, with two exceptions: a count of 1 switches the adjustment off, and a count of 255 means the schedule never runs out.

Commands come in on a valid/ready port. The block takes a command only while `cmd_ready` is high, which is only while it is idle. Register writes go out on a second valid/ready port. While `wr_valid` is high and `wr_ready` is low, the address and data stay frozen, and the write completes on the first clock edge where both are high. The block also keeps the offload control flags: offload enable, group-owner role, discovery, and one enable per descriptor. Plain pins carry these flags together with a step-fault flag.

Top module: `noa_sched_programmer`

## Requirements
- R1: After reset, `cmd_ready` is 1, `wr_valid` is 0, and all flags and `err` are 0.
- R2: An enable command writes, for each descriptor i in turn: the value i<<4 to SEL_ADDR, then duration to DESC_BASE, interval to DESC_BASE+4, adjusted start to DESC_BASE+8 and the count (zero-extended) to DESC_BASE+12.
- R3: When the count is not 1, the start time is increased by the interval for as long as it is less than or equal to the timer value captured for that descriptor plus 51200. The comparison does not wrap.
- R4: Each advance step decrements the count, except that a count of 255 is left unchanged.
- R5: A count of 1 leaves the start time and the count as requested, even when the start time is in the past.
- R6: If an advance step is needed and the interval is zero, or MAX_STEPS steps have already been taken, the loop stops and `err` goes to 1. The writes still go out with the values reached so far, and `err` returns to 0 when the next command is accepted.
- R7: After the descriptor writes of an enable command with opportunistic save requested or at least one descriptor, the block writes 0x10 (bit 4) to RST_ADDR. It then sets offload enable, sets role to `cmd_go` and clears discovery. With neither condition met, no write occurs and these flags are unchanged.
- R8: A descriptor count above 2 is treated as 2. Enable sets `fl_desc_en[i]` for each programmed descriptor i.
- R9: Operation codes are 0 disable, 1 enable, 2 scan and 3 scan done. Scan sets discovery, scan done clears it, and disable clears every flag. None of these three writes any register.
- R10: While `wr_valid` is high and `wr_ready` is low, the write address and data hold. `cmd_ready` stays low until the last write of a command has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high with `cmd_valid` |
| cmd_op | input | 2 | Operation: 0 disable, 1 enable, 2 scan, 3 scan done |
| cmd_num | input | 2 | Number of descriptors (clamped to 2) |
| cmd_opp | input | 1 | Opportunistic power save requested |
| cmd_go | input | 1 | Group-owner role |
| cmd_dur | input | 2x32 | Duration per descriptor |
| cmd_intv | input | 2x32 | Interval per descriptor |
| cmd_start | input | 2x32 | Requested start time per descriptor |
| cmd_cnt | input | 2x8 | Count/type per descriptor |
| tsf | input | 32 | Current timer value |
| wr_valid | output | 1 | Register write offered |
| wr_ready | input | 1 | Register write accepted |
| wr_addr | output | 16 | Register address |
| wr_data | output | 32 | Register data |
| fl_offload | output | 1 | Offload enable flag |
| fl_role | output | 1 | Role flag (1 = group owner) |
| fl_disc | output | 1 | Discovery flag |
| fl_desc_en | output | 2 | Per-descriptor enable flags |
| err | output | 1 | Advance loop stopped by a fault |

## Verification
The bench targets the equality boundary, where the start time is exactly the timer plus the guard. A design that compares with strict less-than would skip the one required step there. The bench also covers count 255, which a careless decrement would wrap to 254, and count 1, which must stay frozen even when the start time is far in the past. It drives a zero interval and an interval small enough to hit the step cap. A design without the cap would hang, and one that dropped the writes on a fault would leave the register sequence short. The remaining cases are a descriptor count of 3, which must produce exactly two descriptor blocks, and a write port throttled to every other cycle, under which the captured write sequence must not change.

// File: rtl/noa_pkg.sv
package noa_pkg;
  typedef enum logic [1:0] {
    OP_DISABLE   = 2'd0,
    OP_ENABLE    = 2'd1,
    OP_SCAN      = 2'd2,
    OP_SCAN_DONE = 2'd3
  } noa_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_SEL, S_DUR, S_INT, S_START, S_CNT, S_RST
  } seq_st_e;
endpackage

// File: rtl/noa_advance.sv
module noa_advance #(
  parameter int TW        = 32,
  parameter int CW        = 8,
  parameter int GUARD     = 51200,
  parameter int MAX_STEPS = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kick,
  input  logic [TW-1:0] tsf,
  input  logic [TW-1:0] intv,
  input  logic [TW-1:0] st_in,
  input  logic [CW-1:0] cnt_in,
  output logic          busy,
  output logic [TW-1:0] res_st,
  output logic [CW-1:0] res_cnt,
  output logic          abort_p
);
  localparam int SW = $clog2(MAX_STEPS + 1);

  logic          run;
  logic [TW-1:0] cur, iv;
  logic [CW-1:0] cnt;
  logic [TW:0]   limit;
  logic [SW-1:0] steps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      cur     <= '0;
      iv      <= '0;
      cnt     <= '0;
      limit   <= '0;
      steps   <= '0;
      abort_p <= 1'b0;
    end else begin
      abort_p <= 1'b0;
      if (kick) begin
        cur   <= st_in;
        cnt   <= cnt_in;
        iv    <= intv;
        limit <= {1'b0, tsf} + (TW+1)'(GUARD);
        steps <= '0;
        run   <= (cnt_in != CW'(1));
      end else if (run) begin
        if ({1'b0, cur} > limit) begin
          run <= 1'b0;
        end else if (iv == '0 || steps == SW'(MAX_STEPS)) begin
          run     <= 1'b0;
          abort_p <= 1'b1;
        end else begin
          cur   <= cur + iv;
          steps <= steps + SW'(1);
          if (cnt != '1) cnt <= cnt - CW'(1);
        end
      end
    end
  end

  assign busy    = run;
  assign res_st  = cur;
  assign res_cnt = cnt;
endmodule

// File: rtl/noa_flags.sv
module noa_flags import noa_pkg::*; #(
  parameter int NDESC = 2,
  parameter int NW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  noa_op_e          op,
  input  logic [NW-1:0]    num,
  input  logic             opp,
  input  logic             go,
  output logic             offload,
  output logic             role,
  output logic             disc,
  output logic [NDESC-1:0] d_en
);
  logic arm;
  assign arm = acc && op == OP_ENABLE && (opp || num != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offload <= 1'b0;
      role    <= 1'b0;
      disc    <= 1'b0;
    end else if (acc) begin
      if (op == OP_DISABLE) begin
        offload <= 1'b0;
        role    <= 1'b0;
        disc    <= 1'b0;
      end else if (op == OP_SCAN) begin
        disc <= 1'b1;
      end else if (op == OP_SCAN_DONE) begin
        disc <= 1'b0;
      end else if (arm) begin
        offload <= 1'b1;
        role    <= go;
        disc    <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < NDESC; i++) begin : g_den
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) d_en[i] <= 1'b0;
      else if (acc && op == OP_DISABLE) d_en[i] <= 1'b0;
      else if (acc && op == OP_ENABLE && num > NW'(i)) d_en[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/noa_sched_programmer.sv
module noa_sched_programmer import noa_pkg::*; #(
  parameter int          NDESC     = 2,
  parameter int          TW        = 32,
  parameter int          CW        = 8,
  parameter int          ADDR_W    = 16,
  parameter int          GUARD     = 51200,
  parameter int          MAX_STEPS = 256,
  parameter logic [15:0] SEL_ADDR  = 16'h05CF,
  parameter logic [15:0] DESC_BASE = 16'h05E0,
  parameter logic [15:0] RST_ADDR  = 16'h0553
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic [1:0]               cmd_op,
  input  logic [$clog2(NDESC+1)-1:0] cmd_num,
  input  logic                     cmd_opp,
  input  logic                     cmd_go,
  input  logic [NDESC-1:0][TW-1:0] cmd_dur,
  input  logic [NDESC-1:0][TW-1:0] cmd_intv,
  input  logic [NDESC-1:0][TW-1:0] cmd_start,
  input  logic [NDESC-1:0][CW-1:0] cmd_cnt,
  input  logic [TW-1:0]            tsf,
  output logic                     wr_valid,
  input  logic                     wr_ready,
  output logic [ADDR_W-1:0]        wr_addr,
  output logic [TW-1:0]            wr_data,
  output logic                     fl_offload,
  output logic                     fl_role,
  output logic                     fl_disc,
  output logic [NDESC-1:0]         fl_desc_en,
  output logic                     err
);
  localparam int NW = $clog2(NDESC + 1);
  localparam int IW = (NDESC > 1) ? $clog2(NDESC) : 1;

  seq_st_e                  st;
  logic [IW-1:0]            idx;
  logic [NW-1:0]            num_q, num_eff;
  logic                     kick, acc, fire, enable_cmd;
  logic [NDESC-1:0][TW-1:0] dur_q, intv_q, start_q;
  logic [NDESC-1:0][CW-1:0] cnt_q;
  logic                     adv_busy, adv_abort;
  logic [TW-1:0]            adv_st;
  logic [CW-1:0]            adv_cnt;

  assign num_eff    = (cmd_num > NW'(NDESC)) ? NW'(NDESC) : cmd_num;
  assign cmd_ready  = (st == S_IDLE);
  assign acc        = cmd_valid && cmd_ready;
  assign fire       = wr_valid && wr_ready;
  assign enable_cmd = acc && noa_op_e'(cmd_op) == OP_ENABLE;

  noa_advance #(.TW(TW), .CW(CW), .GUARD(GUARD), .MAX_STEPS(MAX_STEPS)) u_adv (
    .clk(clk), .rst_n(rst_n), .kick(kick), .tsf(tsf),
    .intv(intv_q[idx]), .st_in(start_q[idx]), .cnt_in(cnt_q[idx]),
    .busy(adv_busy), .res_st(adv_st), .res_cnt(adv_cnt), .abort_p(adv_abort)
  );

  noa_flags #(.NDESC(NDESC), .NW(NW)) u_flags (
    .clk(clk), .rst_n(rst_n), .acc(acc), .op(noa_op_e'(cmd_op)),
    .num(num_eff), .opp(cmd_opp), .go(cmd_go),
    .offload(fl_offload), .role(fl_role), .disc(fl_disc), .d_en(fl_desc_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      idx     <= '0;
      num_q   <= '0;
      kick    <= 1'b0;
      dur_q   <= '0;
      intv_q  <= '0;
      start_q <= '0;
      cnt_q   <= '0;
    end else begin
      kick <= 1'b0;
      unique case (st)
        S_IDLE: if (enable_cmd) begin
          dur_q   <= cmd_dur;
          intv_q  <= cmd_intv;
          start_q <= cmd_start;
          cnt_q   <= cmd_cnt;
          num_q   <= num_eff;
          idx     <= '0;
          if (num_eff != '0) begin
            st   <= S_SEL;
            kick <= 1'b1;
          end else if (cmd_opp) begin
            st <= S_RST;
          end
        end
        S_SEL:   if (fire) st <= S_DUR;
        S_DUR:   if (fire) st <= S_INT;
        S_INT:   if (fire) st <= S_START;
        S_START: if (fire) st <= S_CNT;
        S_CNT: if (fire) begin
          if (NW'(idx) + NW'(1) < num_q) begin
            idx  <= idx + IW'(1);
            st   <= S_SEL;
            kick <= 1'b1;
          end else begin
            st <= S_RST;
          end
        end
        S_RST:   if (fire) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         err <= 1'b0;
    else if (acc)       err <= 1'b0;
    else if (adv_abort) err <= 1'b1;
  end

  always_comb begin
    wr_valid = 1'b0;
    wr_addr  = '0;
    wr_data  = '0;
    unique case (st)
      S_SEL: begin
        wr_valid = 1'b1;
        wr_addr  = ADDR_W'(SEL_ADDR);
        wr_data  = TW'(idx) << 4;
      end
      S_DUR: begin
        wr_valid = 1'b1;
        wr_addr  = ADDR_W'(DESC_BASE);
        wr_data  = dur_q[idx];
      end
      S_INT: begin
        wr_valid = 1'b1;
        wr_addr  = ADDR_W'(DESC_BASE + 16'd4);
        wr_data  = intv_q[idx];
      end
      S_START: begin
        wr_valid = !adv_busy;
        wr_addr  = ADDR_W'(DESC_BASE + 16'd8);
        wr_data  = adv_st;
      end
      S_CNT: begin
        wr_valid = !adv_busy;
        wr_addr  = ADDR_W'(DESC_BASE + 16'd12);
        wr_data  = TW'(adv_cnt);
      end
      S_RST: begin
        wr_valid = 1'b1;
        wr_addr  = ADDR_W'(RST_ADDR);
        wr_data  = TW'(16);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/noa_sched_programmer_chk.sv
module noa_sched_programmer_chk #(
  parameter int          NDESC    = 2,
  parameter int          TW       = 32,
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] SEL_ADDR = 16'h05CF,
  parameter logic [15:0] RST_ADDR = 16'h0553
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [1:0]        cmd_op,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [TW-1:0]     wr_data,
  input logic              fl_offload,
  input logic              fl_disc,
  input logic [NDESC-1:0]  fl_desc_en,
  input logic              err
);
  // R10
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !wr_valid);

  // R7
  rst_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_addr == ADDR_W'(RST_ADDR) |-> wr_data == TW'(16));

  // R2
  sel_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_addr == ADDR_W'(SEL_ADDR) |->
      wr_data[3:0] == 4'd0 && wr_data < TW'(NDESC * 16));

  // R9
  scan_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_op == 2'd2 |=> fl_disc);

  // R9
  disable_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_op == 2'd0 |=>
      !fl_disc && !fl_offload && fl_desc_en == '0);

  // R6
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !cmd_ready);
endmodule

bind noa_sched_programmer noa_sched_programmer_chk #(
  .NDESC(NDESC), .TW(TW), .ADDR_W(ADDR_W), .SEL_ADDR(SEL_ADDR), .RST_ADDR(RST_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
  .wr_data(wr_data), .fl_offload(fl_offload), .fl_disc(fl_disc),
  .fl_desc_en(fl_desc_en), .err(err)
);

// File: tb/noa_sched_programmer_test.sv
module noa_sched_programmer_test;
  localparam logic [15:0] SEL  = 16'h05CF;
  localparam logic [15:0] BASE = 16'h05E0;
  localparam logic [15:0] RSTA = 16'h0553;
  localparam int          MAXS = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [1:0] cmd_op = 2'd0;
  logic [1:0] cmd_num = 2'd0;
  logic cmd_opp = 1'b0;
  logic cmd_go = 1'b0;
  logic [1:0][31:0] cmd_dur = '0;
  logic [1:0][31:0] cmd_intv = '0;
  logic [1:0][31:0] cmd_start = '0;
  logic [1:0][7:0]  cmd_cnt = '0;
  logic [31:0] tsf = '0;
  logic wr_valid;
  logic wr_ready = 1'b1;
  logic [15:0] wr_addr;
  logic [31:0] wr_data;
  logic fl_offload, fl_role, fl_disc, err;
  logic [1:0] fl_desc_en;

  int errors = 0;
  int checks = 0;
  bit bp = 1'b0;
  int cap_n = 0;
  logic [15:0] cap_a [0:31];
  logic [31:0] cap_d [0:31];

  always #10 clk = ~clk;

  noa_sched_programmer uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_num(cmd_num), .cmd_opp(cmd_opp), .cmd_go(cmd_go),
    .cmd_dur(cmd_dur), .cmd_intv(cmd_intv), .cmd_start(cmd_start), .cmd_cnt(cmd_cnt),
    .tsf(tsf), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .fl_offload(fl_offload), .fl_role(fl_role), .fl_disc(fl_disc),
    .fl_desc_en(fl_desc_en), .err(err)
  );

  always @(negedge clk) begin
    wr_ready = bp ? ~wr_ready : 1'b1;
    if (wr_valid && wr_ready && cap_n < 32) begin
      cap_a[cap_n] = wr_addr;
      cap_d[cap_n] = wr_data;
      cap_n = cap_n + 1;
    end
  end

  // tsf fed as a separate argument keeps the guard comparison unwrapped
  localparam logic [159:0] VEC [0:5] = '{
    {32'd1000,    32'd5,  32'd100,   32'd100000, 32'd7},
    {32'h10000,   32'd20, 32'd10000, 32'h10000,  32'd10},
    {32'd2000000, 32'd9,  32'd30000, 32'd1000,   32'd255},
    {32'd90000,   32'd3,  32'd1000,  32'd5,      32'd1},
    {32'd8000,    32'd4,  32'd40,    32'd59200,  32'd3},
    {32'd8000,    32'd6,  32'd40,    32'd59201,  32'd3}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] t, input logic [31:0] iv,
                       input logic [31:0] s, input logic [7:0] c,
                       output logic [31:0] es, output logic [7:0] ec, output bit ab);
    es = s; ec = c; ab = 1'b0;
    if (c != 8'd1) begin
      for (int k = 0; k <= MAXS; k++) begin
        if ({1'b0, es} > ({1'b0, t} + 33'd51200)) break;
        if (iv == 0 || k == MAXS) begin ab = 1'b1; break; end
        es = es + iv;
        if (ec != 8'd255) ec = ec - 8'd1;
      end
    end
  endtask

  task automatic run_cmd(logic [1:0] op, logic [1:0] num, logic opp, logic go);
    @(negedge clk);
    cap_n = 0;
    cmd_op = op; cmd_num = num; cmd_opp = opp; cmd_go = go;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int w = 0; w < 5000 && !cmd_ready; w++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic chk_desc(string req, int k, int i, bit exp_ab);
    logic [31:0] es; logic [7:0] ec; bit ab;
    model(tsf, cmd_intv[i], cmd_start[i], cmd_cnt[i], es, ec, ab);
    chk({req, " sel addr"}, 32'(cap_a[k]), 32'(SEL));
    chk({req, " sel data"}, cap_d[k], 32'(i) << 4);
    chk({req, " dur"}, cap_d[k+1], cmd_dur[i]);
    chk({req, " int addr"}, 32'(cap_a[k+2]), 32'(BASE + 16'd4));
    chk({req, " int"}, cap_d[k+2], cmd_intv[i]);
    chk({req, " start addr"}, 32'(cap_a[k+3]), 32'(BASE + 16'd8));
    chk({req, " start"}, cap_d[k+3], es);
    chk({req, " cnt addr"}, 32'(cap_a[k+4]), 32'(BASE + 16'd12));
    chk({req, " cnt"}, cap_d[k+4], 32'(ec));
    chk({req, " abort model"}, 32'(ab), 32'(exp_ab));
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ready", 32'(cmd_ready), 1);
    chk("R1 wr_valid", 32'(wr_valid), 0);
    chk("R1 flags", {27'd0, fl_offload, fl_role, fl_disc, fl_desc_en}, 0);
    chk("R1 err", 32'(err), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // table: R2 sequence, R3 advance, R4 count, R5 count 1
    foreach (VEC[n]) begin
      tsf = VEC[n][159:128];
      cmd_dur[0] = VEC[n][127:96];
      cmd_intv[0] = VEC[n][95:64];
      cmd_start[0] = VEC[n][63:32];
      cmd_cnt[0] = VEC[n][7:0];
      run_cmd(2'd1, 2'd1, 1'b0, 1'b0);
      chk("R2 write count", 32'(cap_n), 6);
      chk_desc("R3 R4 R5 vector", 0, 0, 1'b0);
      chk("R7 rst addr", 32'(cap_a[5]), 32'(RSTA));
      chk("R7 rst data", cap_d[5], 32'h10);
      chk("R6 no err", 32'(err), 0);
    end
    // explicit expected values for the sharpest corners
    tsf = 32'd8000; cmd_intv[0] = 32'd40; cmd_start[0] = 32'd59200; cmd_cnt[0] = 8'd3;
    run_cmd(2'd1, 2'd1, 1'b0, 1'b0);
    chk("R3 equality steps once", cap_d[3], 32'd59240);
    chk("R4 count decrement", cap_d[4], 32'd2);
    tsf = 32'd2000000; cmd_intv[0] = 32'd30000; cmd_start[0] = 32'd1000; cmd_cnt[0] = 8'd255;
    run_cmd(2'd1, 2'd1, 1'b0, 1'b0);
    chk("R4 count 255 kept", cap_d[4], 32'd255);
    chk("R3 start beyond guard", 32'(cap_d[3] > 32'd2051200), 1);
    tsf = 32'd90000; cmd_start[0] = 32'd5; cmd_cnt[0] = 8'd1;
    run_cmd(2'd1, 2'd1, 1'b0, 1'b0);
    chk("R5 start frozen", cap_d[3], 32'd5);

    // R8 R7 two descriptors, num clamped from 3, group owner
    run_cmd(2'd0, 2'd0, 1'b0, 1'b0);
    tsf = 32'd500;
    cmd_dur = {32'd77, 32'd66}; cmd_intv = {32'd20000, 32'd7000};
    cmd_start = {32'd10, 32'd60000}; cmd_cnt = {8'd50, 8'd9};
    run_cmd(2'd1, 2'd3, 1'b0, 1'b1);
    chk("R8 clamp write count", 32'(cap_n), 11);
    chk_desc("R2 desc0", 0, 0, 1'b0);
    chk_desc("R2 desc1", 5, 1, 1'b0);
    chk("R7 rst last", 32'(cap_a[10]), 32'(RSTA));
    chk("R8 desc enables", 32'(fl_desc_en), 3);
    chk("R7 offload", 32'(fl_offload), 1);
    chk("R7 role", 32'(fl_role), 1);

    // R9 scan, scan done, disable
    run_cmd(2'd2, 2'd0, 1'b0, 1'b0);
    chk("R9 scan sets disc", 32'(fl_disc), 1);
    chk("R9 scan no write", 32'(cap_n), 0);
    run_cmd(2'd1, 2'd0, 1'b1, 1'b0);
    chk("R7 enable clears disc", 32'(fl_disc), 0);
    chk("R7 role cleared", 32'(fl_role), 0);
    chk("R7 opp only one write", 32'(cap_n), 1);
    run_cmd(2'd2, 2'd0, 1'b0, 1'b0);
    run_cmd(2'd3, 2'd0, 1'b0, 1'b0);
    chk("R9 scan done clears disc", 32'(fl_disc), 0);
    run_cmd(2'd0, 2'd0, 1'b0, 1'b0);
    chk("R9 disable clears", {28'd0, fl_offload, fl_role, fl_desc_en}, 0);
    run_cmd(2'd1, 2'd0, 1'b0, 1'b0);
    chk("R7 nothing to do no write", 32'(cap_n), 0);
    chk("R7 offload stays 0", 32'(fl_offload), 0);

    // R6 zero interval and step cap
    tsf = 32'd100000; cmd_intv[0] = 32'd0; cmd_start[0] = 32'd50; cmd_cnt[0] = 8'd255;
    run_cmd(2'd1, 2'd1, 1'b0, 1'b0);
    chk("R6 zero interval err", 32'(err), 1);
    chk("R6 writes still out", 32'(cap_n), 6);
    chk("R6 start unchanged", cap_d[3], 32'd50);
    run_cmd(2'd3, 2'd0, 1'b0, 1'b0);
    chk("R6 err cleared", 32'(err), 0);
    tsf = 32'd1000000; cmd_intv[0] = 32'd1; cmd_start[0] = 32'd0;
    run_cmd(2'd1, 2'd1, 1'b0, 1'b0);
    chk("R6 cap err", 32'(err), 1);
    chk("R6 cap start", cap_d[3], 32'd256);

    // R10 back-pressure gives the same sequence
    bp = 1'b1;
    tsf = 32'h10000; cmd_dur[0] = 32'd20; cmd_intv[0] = 32'd10000;
    cmd_start[0] = 32'h10000; cmd_cnt[0] = 8'd10;
    run_cmd(2'd1, 2'd1, 1'b0, 1'b0);
    bp = 1'b0;
    chk("R10 bp write count", 32'(cap_n), 6);
    chk_desc("R10 bp desc", 0, 0, 1'b0);
    chk("R10 bp start", cap_d[3], 32'd125536);
    chk("R10 bp cnt", cap_d[4], 32'd4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule